// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Matrix

This block lets a fixed set of processor agents raise interrupts on one another through a small register bus. Each agent owns one channel. A channel has a send side and a receive side. On the send side, a trigger register fires interrupts at chosen destinations, and an observation register shows which of those requests are still pending. On the receive side, a status/clear register, a mask register, an enable register and a disable register control the incoming requests. The block drives one level interrupt line per destination agent.

Every bus access carries the identifier of the agent making it. An access is served only when that identifier equals the addressed channel index. Any other access is rejected with a one-cycle error response and has no effect on any state. The observation register of a sender is the transpose of the status matrix: its bit d shows whether destination d still holds the sender's request, so the sender can see when each target has serviced it.

Responses are sequenced by a three-state machine: `ST_IDLE`, `ST_GRANT` and `ST_DENY`. It moves as follows:

- From any state, a request from the owning agent moves it to `ST_GRANT`.
- From any state, a request from any other agent moves it to `ST_DENY`.
- From any state, no request returns it to `ST_IDLE`.

Each non-idle state lasts exactly one cycle and presents the response for the preceding request.

Top module: `ipi_matrix`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1, every interrupt output is 0 and no response is pending.
- R2: A granted write to register code 0 (trigger) of channel s with bit d set in the write data sets bit s of destination d's status. Status bits are cleared only by their owner.
- R3: Interrupt output d is 1 exactly when some bit of destination d's status is 1 and the matching mask bit is 0.
- R4: A read of register code 1 (observation) of channel s returns, in bit d, bit s of destination d's status. Writes to this register change nothing.
- R5: A granted write to register code 2 (status) clears each status bit written with 1 and leaves bits written with 0 unchanged. A read of this register returns the status vector.
- R6: A granted write to register code 4 (enable) clears the mask bits written with 1. A write to code 5 (disable) sets them. Code 3 (mask) reads the mask and ignores writes.
- R7: An access whose agent identifier differs from the channel index is ignored. Its response has the error flag at 1 and read data 0.
- R8: The trigger register and the unused codes 6 and 7 read as 0.
- R9: A request accepted at a clock edge produces, after that edge, a single response cycle with the valid flag at 1. The valid flag is 0 in any cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one access per cycle |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_agent_i | input | ID_W | Identifier of the requesting agent |
| req_chan_i | input | ID_W | Addressed channel index |
| req_reg_i | input | 3 | Register code within the channel |
| req_wdata_i | input | N_AGENTS | Write data, one bit per agent |
| rsp_valid_o | output | 1 | Response present |
| rsp_err_o | output | 1 | Access rejected by the ownership check |
| rsp_rdata_o | output | N_AGENTS | Read data (0 for writes and rejected accesses) |
| irq_o | output | N_AGENTS | Level interrupt, one per destination agent |

## Verification
The bench is built with four agents. It first walks every source/destination pair in turn with single-bit triggers. Each pair is checked through the destination's status, the sender's observation, and the interrupt line with the mask both set and cleared. This separates a transposed index from a straight one and shows that the mask gates the interrupt. Broadcast triggers with all-ones data are then mixed with zero-valued clears. These show that only the written bits change. Finally, every agent attempts every register of every foreign channel, to show that rejected accesses leave each status and mask bit as the model predicts.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        REG_TRIG = 3'd0,
        REG_OBS  = 3'd1,
        REG_STAT = 3'd2,
        REG_MASK = 3'd3,
        REG_EN   = 3'd4,
        REG_DIS  = 3'd5
    } reg_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/ipi_access_ctrl.sv
module ipi_access_ctrl
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 10,
    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_we_i,
    input  logic [ID_W-1:0]     req_agent_i,
    input  logic [ID_W-1:0]     req_chan_i,
    input  logic [2:0]          req_reg_i,
    input  logic [N_AGENTS-1:0] rd_value_i,
    output logic                trig_stb_o,
    output logic                clr_stb_o,
    output logic                en_stb_o,
    output logic                dis_stb_o,
    output logic                rsp_valid_o,
    output logic                rsp_err_o,
    output logic [N_AGENTS-1:0] rsp_rdata_o
);

    rsp_state_e state_q, state_d;
    logic [N_AGENTS-1:0] rdata_q;
    logic grant, wr_ok;

    always_comb begin
        grant = req_valid_i && (req_agent_i == req_chan_i)
                && (32'(req_chan_i) < N_AGENTS);
        wr_ok = grant && req_we_i;
    end

    // write strobes toward the channel storage
    always_comb begin
        trig_stb_o = wr_ok && (req_reg_i == REG_TRIG);
        clr_stb_o  = wr_ok && (req_reg_i == REG_STAT);
        en_stb_o   = wr_ok && (req_reg_i == REG_EN);
        dis_stb_o  = wr_ok && (req_reg_i == REG_DIS);
    end

    // next-state decision
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (req_valid_i) state_d = grant ? ST_GRANT : ST_DENY;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (grant && !req_we_i) ? rd_value_i : '0;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_err_o   = 1'b0;
        rsp_rdata_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRANT: begin
                rsp_valid_o = 1'b1;
                rsp_rdata_o = rdata_q;
            end
            ST_DENY: begin
                rsp_valid_o = 1'b1;
                rsp_err_o   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ipi_dest_channel.sv
module ipi_dest_channel #(
    parameter int N_AGENTS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] set_i,
    input  logic [N_AGENTS-1:0] clr_i,
    input  logic [N_AGENTS-1:0] unmask_i,
    input  logic [N_AGENTS-1:0] mask_set_i,
    output logic [N_AGENTS-1:0] status_o,
    output logic [N_AGENTS-1:0] mask_o,
    output logic                irq_o
);

    logic [N_AGENTS-1:0] status_q, mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            // a set arriving with a clear on the same bit takes priority
            status_q <= (status_q & ~clr_i) | set_i;
            mask_q   <= (mask_q & ~unmask_i) | mask_set_i;
        end
    end

    always_comb begin
        status_o = status_q;
        mask_o   = mask_q;
        irq_o    = |(status_q & ~mask_q);
    end

endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 10,
    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [ID_W-1:0]                   chan_i,
    input  logic [2:0]                        reg_i,
    input  logic [N_AGENTS-1:0][N_AGENTS-1:0] status_i,
    input  logic [N_AGENTS-1:0][N_AGENTS-1:0] mask_i,
    output logic [N_AGENTS-1:0]               value_o
);

    logic in_range;
    logic [N_AGENTS-1:0] obs_col;

    always_comb begin
        in_range = 32'(chan_i) < N_AGENTS;
        for (int d = 0; d < N_AGENTS; d++) begin
            obs_col[d] = in_range ? status_i[d][chan_i] : 1'b0;
        end
    end

    always_comb begin
        value_o = '0;
        if (in_range) begin
            case (reg_i)
                REG_OBS:  value_o = obs_col;
                REG_STAT: value_o = status_i[chan_i];
                REG_MASK: value_o = mask_i[chan_i];
                default:  value_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_matrix.sv
module ipi_matrix
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 10,
    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_we_i,
    input  logic [ID_W-1:0]     req_agent_i,
    input  logic [ID_W-1:0]     req_chan_i,
    input  logic [2:0]          req_reg_i,
    input  logic [N_AGENTS-1:0] req_wdata_i,
    output logic                rsp_valid_o,
    output logic                rsp_err_o,
    output logic [N_AGENTS-1:0] rsp_rdata_o,
    output logic [N_AGENTS-1:0] irq_o
);

    logic trig_stb, clr_stb, en_stb, dis_stb;
    logic [N_AGENTS-1:0] rd_value;
    logic [N_AGENTS-1:0][N_AGENTS-1:0] status_mat, mask_mat;

    ipi_access_ctrl #(.N_AGENTS(N_AGENTS)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_we_i    (req_we_i),
        .req_agent_i (req_agent_i),
        .req_chan_i  (req_chan_i),
        .req_reg_i   (req_reg_i),
        .rd_value_i  (rd_value),
        .trig_stb_o  (trig_stb),
        .clr_stb_o   (clr_stb),
        .en_stb_o    (en_stb),
        .dis_stb_o   (dis_stb),
        .rsp_valid_o (rsp_valid_o),
        .rsp_err_o   (rsp_err_o),
        .rsp_rdata_o (rsp_rdata_o)
    );

    ipi_read_mux #(.N_AGENTS(N_AGENTS)) rmux_i (
        .chan_i   (req_chan_i),
        .reg_i    (req_reg_i),
        .status_i (status_mat),
        .mask_i   (mask_mat),
        .value_o  (rd_value)
    );

    for (genvar d = 0; d < N_AGENTS; d++) begin : g_dest
        logic [N_AGENTS-1:0] set_v, clr_v, unmask_v, mset_v;
        logic own;

        always_comb begin
            own      = (32'(req_chan_i) == d);
            set_v    = '0;
            if (trig_stb) set_v[req_chan_i] = req_wdata_i[d];
            clr_v    = (clr_stb && own) ? req_wdata_i : '0;
            unmask_v = (en_stb  && own) ? req_wdata_i : '0;
            mset_v   = (dis_stb && own) ? req_wdata_i : '0;
        end

        ipi_dest_channel #(.N_AGENTS(N_AGENTS)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_v),
            .clr_i      (clr_v),
            .unmask_i   (unmask_v),
            .mask_set_i (mset_v),
            .status_o   (status_mat[d]),
            .mask_o     (mask_mat[d]),
            .irq_o      (irq_o[d])
        );
    end

endmodule

// File: rtl/ipi_matrix_chk.sv
module ipi_matrix_chk #(
    parameter int N_AGENTS = 10,
    localparam int ID_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                req_valid_i,
    input logic                                req_we_i,
    input logic [ID_W-1:0]                     req_agent_i,
    input logic [ID_W-1:0]                     req_chan_i,
    input logic [2:0]                          req_reg_i,
    input logic                                rsp_valid_o,
    input logic                                rsp_err_o,
    input logic [N_AGENTS-1:0]                 rsp_rdata_o,
    input logic [N_AGENTS-1:0]                 irq_o,
    input logic [N_AGENTS-1:0][N_AGENTS-1:0]   status_mat,
    input logic [N_AGENTS-1:0][N_AGENTS-1:0]   mask_mat
);

    logic [N_AGENTS*N_AGENTS-1:0] st_flat, mk_flat;
    assign st_flat = status_mat;
    assign mk_flat = mask_mat;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i)); // R9

    AST_DENY_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0)); // R7

    AST_DENY_ON_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_agent_i != req_chan_i) |=> rsp_err_o); // R7

    AST_STATUS_RISE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_flat & ~$past(st_flat))) |->
            $past(req_valid_i && req_we_i && req_reg_i == 3'd0
                  && req_agent_i == req_chan_i)); // R2

    AST_MASK_RISE_NEEDS_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mk_flat & ~$past(mk_flat))) |->
            $past(req_valid_i && req_we_i && req_reg_i == 3'd5
                  && req_agent_i == req_chan_i)); // R6

    for (genvar d = 0; d < N_AGENTS; d++) begin : g_irq
        AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[d] |-> (|status_mat[d])); // R3
    end

endmodule

bind ipi_matrix ipi_matrix_chk #(.N_AGENTS(N_AGENTS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_agent_i (req_agent_i),
    .req_chan_i  (req_chan_i),
    .req_reg_i   (req_reg_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .irq_o       (irq_o),
    .status_mat  (status_mat),
    .mask_mat    (mask_mat)
);

// File: tb/ipi_matrix_tb_top.sv
module ipi_matrix_tb_top;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [IW-1:0] req_agent = '0;
    logic [IW-1:0] req_chan = '0;
    logic [2:0]    req_reg = '0;
    logic [N-1:0]  req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [N-1:0]  rsp_rdata, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N-1:0] m_st [N];
    logic [N-1:0] m_mk [N];
    logic [N-1:0] got;
    logic         got_err;

    always #5 clk = ~clk;

    ipi_matrix #(.N_AGENTS(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_we_i    (req_we),
        .req_agent_i (req_agent),
        .req_chan_i  (req_chan),
        .req_reg_i   (req_reg),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .rsp_rdata_o (rsp_rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one access: drive at a falling edge, sample the response at the next one
    task automatic acc(input int ag, input int ch, input int rg,
                       input bit we, input logic [N-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_agent = IW'(ag);
        req_chan = IW'(ch); req_reg = 3'(rg); req_wdata = wd;
        @(negedge clk);
        got = rsp_rdata; got_err = rsp_err;
        check("R9 valid", int'(rsp_valid), 1);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] v;
        for (int d = 0; d < N; d++) v[d] = |(m_st[d] & ~m_mk[d]);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_obs(input int s);
        logic [N-1:0] v;
        for (int d = 0; d < N; d++) v[d] = m_st[d][s];
        return v;
    endfunction

    task automatic model_trig(input int s, input logic [N-1:0] wd);
        for (int d = 0; d < N; d++) if (wd[d]) m_st[d][s] = 1'b1;
    endtask

    task automatic verify_all(input string tag);
        for (int a = 0; a < N; a++) begin
            acc(a, a, 2, 0, '0); check({tag, " R5 status"}, int'(got), int'(m_st[a]));
            acc(a, a, 3, 0, '0); check({tag, " R6 mask"}, int'(got), int'(m_mk[a]));
            acc(a, a, 1, 0, '0); check({tag, " R4 obs"}, int'(got), int'(exp_obs(a)));
        end
        check({tag, " R3 irq"}, int'(irq), int'(exp_irq()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < N; d++) begin m_st[d] = '0; m_mk[d] = '1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 rsp_valid", int'(rsp_valid), 0);
        verify_all("R1");
        @(negedge clk);
        check("R9 idle no valid", int'(rsp_valid), 0);

        // R2/R3/R4/R5/R6 pairwise sweep
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                acc(s, s, 0, 1, N'(1) << d); model_trig(s, N'(1) << d);
                check("R2 no err", int'(got_err), 0);
                acc(d, d, 2, 0, '0); check("R2 status", int'(got), int'(m_st[d]));
                acc(s, s, 1, 0, '0); check("R4 obs set", int'(got), int'(exp_obs(s)));
                check("R3 masked", int'(irq), int'(exp_irq()));
                acc(d, d, 4, 1, N'(1) << s); m_mk[d][s] = 1'b0;
                check("R3 unmasked", int'(irq), int'(exp_irq()));
                check("R3 line high", int'(irq[d]), 1);
                acc(d, d, 2, 1, N'(1) << s); m_st[d][s] = 1'b0;
                check("R5 cleared irq", int'(irq), int'(exp_irq()));
                acc(s, s, 1, 0, '0); check("R4 obs drop", int'(got), int'(exp_obs(s)));
                acc(d, d, 5, 1, N'(1) << s); m_mk[d][s] = 1'b1;
                acc(d, d, 3, 0, '0); check("R6 mask back", int'(got), int'(m_mk[d]));
            end
        end

        // broadcast triggers and zero-valued clears
        acc(0, 0, 0, 1, '1); model_trig(0, '1);
        acc(2, 2, 0, 1, N'(4'b1010)); model_trig(2, N'(4'b1010));
        acc(0, 0, 0, 0, '0); check("R8 trigger reads zero", int'(got), 0);
        acc(1, 1, 6, 0, '0); check("R8 code 6 zero", int'(got), 0);
        acc(1, 1, 7, 0, '0); check("R8 code 7 zero", int'(got), 0);
        acc(1, 1, 2, 1, '0);
        acc(3, 3, 2, 1, N'(4'b0001)); m_st[3][0] = 1'b0;
        acc(0, 0, 1, 1, '0);
        acc(2, 2, 3, 1, '0);
        acc(1, 1, 4, 1, '1); m_mk[1] = '0;
        acc(3, 3, 4, 1, N'(4'b0100)); m_mk[3][2] = 1'b0;
        verify_all("R5 R6 R4 broadcast");

        // R7 foreign accesses: every agent, every other channel, every code
        for (int a = 0; a < N; a++) begin
            for (int c = 0; c < N; c++) begin
                if (c != a) begin
                    for (int r = 0; r < 8; r++) begin
                        acc(a, c, r, 1, '1);
                        check("R7 write err", int'(got_err), 1);
                        check("R7 write data", int'(got), 0);
                    end
                    acc(a, c, 2, 0, '0);
                    check("R7 read err", int'(got_err), 1);
                    check("R7 read zero", int'(got), 0);
                end
            end
        end
        verify_all("R7 untouched");
        @(negedge clk);
        check("R9 pulse ends", int'(rsp_valid), 0);
        check("R7 err ends", int'(rsp_err), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule